// File: doc/BRIEF.md
# Core Idle State Controller

This block sequences one processor core through its idle states. Software asks for a visible idle level: active, halt, stop-most-clocks or stop-all-clocks. The block then raises nested clock-gate enables for that level and reports the level on a two-bit status output. While the core idles, a residency counter counts a free-running timer tick. When the core stays in halt long enough, the block moves on its own into an enhanced halt. When it stays in stop-all long enough, it steps down through three deeper hidden levels that also request a reduced core voltage. None of the hidden levels is ever shown to software. Enhanced halt reads back as stop-most, and the three deeper levels read back as stop-all.

A wake input ends any idle level with a fixed sequence. The voltage request is dropped first, and the clocks stay gated until the supply reports good. The clocks are then ungated, and the core becomes active after an exit latency that depends on the level it left. Frequency and voltage operating-point updates are taken only while the core is active. Support for the two deeper visible levels is a build option. A request for a level the build lacks falls back to the deepest level the build has that is not deeper than the one requested.

Top module: `cidle_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, status_o is 0, all three gate outputs and lowv_req_o are 0, and pstate_o is 0.
- R2: Status codes are 0 = active, 1 = halt, 2 = stop-most, 3 = stop-all. A request (req_valid_i high with req_state_i nonzero) is taken only while the core is active and wake_i is low, and status_o shows the new level one cycle later. A request made in any other situation leaves status_o unchanged.
- R3: Gate outputs follow the level from the cycle after entry. Halt raises gate_halt_o only. Stop-most raises gate_halt_o and gate_most_o. Stop-all and every deeper level raise all three outputs.
- R4: With stop-most and stop-all both disabled by parameter, requests for code 2 or code 3 enter halt (status 1).
- R5: The residency count restarts at zero on every state change, increments on each tick_i and holds at its maximum instead of wrapping. In halt, the cycle after the count reaches c1e_thr_i the core enters enhanced halt: status 2, with gate_halt_o and gate_most_o high.
- R6: In stop-all and in each of the first two deeper levels, the cycle after the count reaches deep_thr_i the core steps one level deeper, to at most three deeper levels. lowv_req_o is high in every deeper level and status_o stays 3.
- R7: On wake_i, lowv_req_o falls the next cycle while the gates and status_o are held. They remain held for as long as vgood_i is low.
- R8: After vgood_i is seen, all gates fall on the next cycle. status_o becomes 0 exactly LAT cycles after the gates fall. LAT is 2 for halt, 3 for enhanced halt, 4 for stop-most, 5 for stop-all and 6, 7, 8 for the three deeper levels.
- R9: pstate_o loads pstate_i on pstate_valid_i only while the core is active. At any other time it holds its value.
- R10: The gate outputs never change in the same cycle as lowv_req_o, and lowv_req_o is never high without gate_all_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Idle request strobe |
| req_state_i | input | 2 | Requested visible level |
| wake_i | input | 1 | Wake or interrupt |
| tick_i | input | 1 | Residency timer tick |
| c1e_thr_i | input | RW | Halt residency before enhanced halt |
| deep_thr_i | input | RW | Residency before each deeper step |
| vgood_i | input | 1 | Supply at nominal voltage |
| pstate_valid_i | input | 1 | Operating-point update strobe |
| pstate_i | input | PW | New operating point |
| pstate_o | output | PW | Current operating point |
| gate_halt_o | output | 1 | Gate the few halt clocks |
| gate_most_o | output | 1 | Gate most core clocks |
| gate_all_o | output | 1 | Gate all core clocks |
| lowv_req_o | output | 1 | Reduced-voltage request |
| status_o | output | 2 | Visible idle level |

## Verification
The bench aims at the exact residency boundary. A count compared with the wrong bound promotes one tick early or one tick late, and the status code changes in the wrong cycle. It holds vgood_i low during a wake from the deepest level. A design that ungates before the supply recovers, or that moves the gates and the voltage request together, is then caught on the gate outputs. Exit latency is timed for several source levels, so a timer that is off by one, or that uses the wrong level's latency, shows up as a wrong cycle count. A second instance, built without the optional levels, shows whether requests fall back to halt, and operating-point writes made while idle must leave pstate_o unchanged.

// File: rtl/cidle_pkg.sv
package cidle_pkg;
  typedef enum logic [3:0] {
    ST_C0, ST_C1, ST_C1E, ST_C2, ST_C3, ST_C4, ST_C5, ST_C6, ST_WVOLT, ST_WEXIT
  } cstate_e;

  function automatic logic [1:0] vis_code(cstate_e s);
    case (s)
      ST_C0:          return 2'd0;
      ST_C1:          return 2'd1;
      ST_C1E, ST_C2:  return 2'd2;
      default:        return 2'd3;
    endcase
  endfunction

  function automatic cstate_e deeper(cstate_e s);
    case (s)
      ST_C3:   return ST_C4;
      ST_C4:   return ST_C5;
      default: return ST_C6;
    endcase
  endfunction
endpackage

// File: rtl/cidle_demote.sv
module cidle_demote
  import cidle_pkg::*;
#(
  parameter bit EN_C2 = 1'b1,
  parameter bit EN_C3 = 1'b1
) (
  input  logic [1:0] req_i,
  output cstate_e    st_o
);
  localparam cstate_e C2_MAP = EN_C2 ? ST_C2 : ST_C1;
  localparam cstate_e C3_MAP = EN_C3 ? ST_C3 : C2_MAP;

  always_comb begin
    case (req_i)
      2'd0:    st_o = ST_C0;
      2'd1:    st_o = ST_C1;
      2'd2:    st_o = C2_MAP;
      default: st_o = C3_MAP;
    endcase
  end
endmodule

// File: rtl/cidle_resid.sv
module cidle_resid #(
  parameter int unsigned RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  output logic [RW-1:0] cnt_o
);
  localparam logic [RW-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_o <= '0;
    else if (clr_i)                 cnt_o <= '0;
    else if (tick_i && cnt_o != MAX) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/cidle_exit_tmr.sv
module cidle_exit_tmr #(
  parameter int unsigned TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  input  logic          dec_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/cidle_ctrl.sv
module cidle_ctrl
  import cidle_pkg::*;
#(
  parameter bit          EN_C2  = 1'b1,
  parameter bit          EN_C3  = 1'b1,
  parameter int unsigned RW     = 8,
  parameter int unsigned PW     = 3,
  parameter int unsigned LAT_C1 = 2,
  parameter int unsigned LAT_C1E = 3,
  parameter int unsigned LAT_C2 = 4,
  parameter int unsigned LAT_C3 = 5,
  parameter int unsigned LAT_C4 = 6,
  parameter int unsigned LAT_C5 = 7,
  parameter int unsigned LAT_C6 = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    req_state_i,
  input  logic          wake_i,
  input  logic          tick_i,
  input  logic [RW-1:0] c1e_thr_i,
  input  logic [RW-1:0] deep_thr_i,
  input  logic          vgood_i,
  input  logic          pstate_valid_i,
  input  logic [PW-1:0] pstate_i,
  output logic [PW-1:0] pstate_o,
  output logic          gate_halt_o,
  output logic          gate_most_o,
  output logic          gate_all_o,
  output logic          lowv_req_o,
  output logic [1:0]    status_o
);
  localparam int unsigned LAT_MAX = LAT_C6 > LAT_C5 ? (LAT_C6 > LAT_C4 ? LAT_C6 : LAT_C4)
                                  : (LAT_C5 > LAT_C4 ? LAT_C5 : LAT_C4);
  localparam int unsigned TW = $clog2(LAT_MAX + 1);

  cstate_e       st_q, st_d, src_q, req_st, gs;
  logic [RW-1:0] res_q;
  logic          res_clr, tmr_load, tmr_done, in_wake;
  logic [TW-1:0] tmr_val;

  cidle_demote #(.EN_C2(EN_C2), .EN_C3(EN_C3)) u_dem (
    .req_i(req_state_i), .st_o(req_st)
  );

  cidle_resid #(.RW(RW)) u_res (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(res_clr), .tick_i(tick_i), .cnt_o(res_q)
  );

  // exit latency minus one: the last WEXIT cycle sees zero
  always_comb begin
    case (src_q)
      ST_C1:   tmr_val = TW'(LAT_C1 - 1);
      ST_C1E:  tmr_val = TW'(LAT_C1E - 1);
      ST_C2:   tmr_val = TW'(LAT_C2 - 1);
      ST_C3:   tmr_val = TW'(LAT_C3 - 1);
      ST_C4:   tmr_val = TW'(LAT_C4 - 1);
      ST_C5:   tmr_val = TW'(LAT_C5 - 1);
      default: tmr_val = TW'(LAT_C6 - 1);
    endcase
  end

  assign tmr_load = (st_q == ST_WVOLT) && vgood_i;

  cidle_exit_tmr #(.TW(TW)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .val_i(tmr_val),
    .dec_i(st_q == ST_WEXIT), .done_o(tmr_done)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_C0: if (req_valid_i && !wake_i && req_st != ST_C0) st_d = req_st;
      ST_C1: begin
        if (wake_i)                  st_d = ST_WVOLT;
        else if (res_q >= c1e_thr_i) st_d = ST_C1E;
      end
      ST_C3, ST_C4, ST_C5: begin
        if (wake_i)                   st_d = ST_WVOLT;
        else if (res_q >= deep_thr_i) st_d = deeper(st_q);
      end
      ST_C1E, ST_C2, ST_C6: if (wake_i) st_d = ST_WVOLT;
      ST_WVOLT: if (vgood_i) st_d = ST_WEXIT;
      ST_WEXIT: if (tmr_done) st_d = ST_C0;
      default:  st_d = ST_C0;
    endcase
  end

  assign res_clr = (st_d != st_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_C0;
      src_q    <= ST_C0;
      pstate_o <= '0;
    end else begin
      st_q <= st_d;
      if (st_d == ST_WVOLT && st_q != ST_WVOLT) src_q <= st_q;
      if (st_q == ST_C0 && pstate_valid_i) pstate_o <= pstate_i;
    end
  end

  // gating holds the source level until the supply is good
  assign in_wake = (st_q == ST_WVOLT) || (st_q == ST_WEXIT);
  assign gs      = (st_q == ST_WVOLT) ? src_q : (st_q == ST_WEXIT) ? ST_C0 : st_q;

  assign gate_halt_o = (gs != ST_C0);
  assign gate_most_o = (gs != ST_C0) && (gs != ST_C1);
  assign gate_all_o  = gs inside {ST_C3, ST_C4, ST_C5, ST_C6};
  assign lowv_req_o  = st_q inside {ST_C4, ST_C5, ST_C6};
  assign status_o    = in_wake ? vis_code(src_q) : vis_code(st_q);
endmodule

// File: rtl/cidle_chk.sv
module cidle_chk #(
  parameter int unsigned RW = 8,
  parameter int unsigned PW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          gate_halt_o,
  input logic          gate_most_o,
  input logic          gate_all_o,
  input logic          lowv_req_o,
  input logic [1:0]    status_o,
  input logic [PW-1:0] pstate_o,
  input logic [RW-1:0] res_cnt,
  input logic          res_clr
);
  localparam logic [RW-1:0] MAX = '1;

  a_r10_gate_volt_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lowv_req_o) |-> $stable({gate_halt_o, gate_most_o, gate_all_o}));

  a_r10_lowv_all_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lowv_req_o |-> gate_all_o);

  a_r3_all_nests_most: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_all_o |-> gate_most_o);

  a_r3_most_nests_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_most_o |-> gate_halt_o);

  a_r9_pstate_active_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pstate_o) |-> $past(status_o) == 2'd0);

  a_r5_res_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(res_cnt) == MAX && !$past(res_clr)) |-> res_cnt == MAX);

  a_r6_lowv_reports_c3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lowv_req_o |-> status_o == 2'd3);

  a_r7_ungate_after_volt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_all_o) |-> !lowv_req_o && !$past(lowv_req_o));
endmodule

bind cidle_ctrl cidle_chk #(.RW(RW), .PW(PW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .gate_halt_o(gate_halt_o), .gate_most_o(gate_most_o),
  .gate_all_o(gate_all_o), .lowv_req_o(lowv_req_o), .status_o(status_o),
  .pstate_o(pstate_o), .res_cnt(res_q), .res_clr(res_clr)
);

// File: tb/cidle_ctrl_tb_top.sv
module cidle_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, wake = 1'b0, tick = 1'b0, vgood = 1'b1, pst_valid = 1'b0;
  logic [1:0] req_code = 2'd0;
  logic [2:0] pst_val = 3'd0;
  logic [7:0] c1e_thr = 8'd3, deep_thr = 8'd2;

  logic [2:0] pst_o, l_pst_o;
  logic       g_h, g_m, g_a, lv, l_g_h, l_g_m, l_g_a, l_lv;
  logic [1:0] st_o, l_st_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cidle_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_state_i(req_code),
    .wake_i(wake), .tick_i(tick), .c1e_thr_i(c1e_thr), .deep_thr_i(deep_thr),
    .vgood_i(vgood), .pstate_valid_i(pst_valid), .pstate_i(pst_val), .pstate_o(pst_o),
    .gate_halt_o(g_h), .gate_most_o(g_m), .gate_all_o(g_a), .lowv_req_o(lv), .status_o(st_o)
  );

  cidle_ctrl #(.EN_C2(1'b0), .EN_C3(1'b0)) dut_lite_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_state_i(req_code),
    .wake_i(wake), .tick_i(tick), .c1e_thr_i(c1e_thr), .deep_thr_i(deep_thr),
    .vgood_i(vgood), .pstate_valid_i(pst_valid), .pstate_i(pst_val), .pstate_o(l_pst_o),
    .gate_halt_o(l_g_h), .gate_most_o(l_g_m), .gate_all_o(l_g_a), .lowv_req_o(l_lv),
    .status_o(l_st_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model codes: 0..6 = C0..C6, 7 = enhanced halt, 8 = wait volt, 9 = exit
  int m_st = 0, m_src = 0, m_res = 0, m_tmr = 0, m_ps = 0;

  function automatic int lat_of(int s);
    case (s)
      1: return 2; 7: return 3; 2: return 4; 3: return 5;
      4: return 6; 5: return 7; default: return 8;
    endcase
  endfunction

  function automatic int vis_of(int s);
    if (s == 0) return 0;
    if (s == 1) return 1;
    if (s == 2 || s == 7) return 2;
    return 3;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_src = 0; m_res = 0; m_tmr = 0; m_ps = 0;
    end else begin
      int nst;
      nst = m_st;
      if (m_st == 0 && pst_valid) m_ps = pst_val;
      if (m_st == 0) begin
        if (req_valid && !wake && req_code != 0) nst = req_code;
      end else if (m_st >= 1 && m_st <= 7) begin
        if (wake) begin nst = 8; m_src = m_st; end
        else if (m_st == 1 && m_res >= c1e_thr) nst = 7;
        else if (m_st >= 3 && m_st <= 5 && m_res >= deep_thr) nst = m_st + 1;
      end else if (m_st == 8) begin
        if (vgood) begin nst = 9; m_tmr = lat_of(m_src) - 1; end
      end else begin
        if (m_tmr == 0) nst = 0; else m_tmr--;
      end
      if (nst != m_st) m_res = 0;
      else if (tick && m_res < 255) m_res++;
      m_st = nst;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int gs;
      gs = (m_st == 8) ? m_src : (m_st == 9) ? 0 : m_st;
      chk("R2 status", st_o, (m_st >= 8) ? vis_of(m_src) : vis_of(m_st));
      chk("R3 gate_halt", g_h, gs != 0);
      chk("R3 gate_most", g_m, gs >= 2);
      chk("R3 gate_all", g_a, gs >= 3 && gs <= 6);
      chk("R6 lowv", lv, m_st >= 4 && m_st <= 6);
      chk("R9 pstate", pst_o, m_ps);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_req(logic [1:0] c);
    @(negedge clk); req_valid = 1'b1; req_code = c;
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic do_tick(int n);
    repeat (n) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic do_wake();
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
  endtask

  // counts cycles with gates low until the status returns to active
  task automatic measure(string tag, int exp);
    int n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (st_o == 2'd0) break;
      if (!g_h) n++;
    end
    chk(tag, n, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(1);
    chk("R1 status in reset", st_o, 0);
    chk("R1 gates in reset", {g_h, g_m, g_a, lv}, 0);
    cyc(2);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 status after reset", st_o, 0);
    chk("R1 pstate after reset", pst_o, 0);
    chk("R1 lowv after reset", lv, 0);

    @(negedge clk); pst_valid = 1'b1; pst_val = 3'd5;
    @(negedge clk); pst_valid = 1'b0;
    chk("R9 pstate taken in active", pst_o, 5);

    do_req(2'd1);
    chk("R2 halt entered", st_o, 1);
    chk("R3 halt gates", {g_h, g_m, g_a}, 3'b100);
    @(negedge clk); pst_valid = 1'b1; pst_val = 3'd2;
    @(negedge clk); pst_valid = 1'b0;
    chk("R9 pstate ignored in halt", pst_o, 5);
    do_req(2'd3);
    chk("R2 request ignored in halt", st_o, 1);

    do_tick(2);
    do_tick(1);
    chk("R5 no promotion before threshold seen", st_o, 1);
    cyc(1);
    chk("R5 enhanced halt reported as 2", st_o, 2);
    chk("R5 enhanced halt gates", {g_h, g_m, g_a}, 3'b110);
    do_wake();
    measure("R8 latency from enhanced halt", 3);

    do_req(2'd2);
    chk("R2 stop-most entered", st_o, 2);
    chk("R3 stop-most gates", {g_h, g_m, g_a}, 3'b110);
    chk("R4 lite demotes 2 to halt", l_st_o, 1);
    do_wake();
    measure("R8 latency from stop-most", 4);
    cyc(4);

    do_req(2'd3);
    chk("R2 stop-all entered", st_o, 3);
    chk("R3 stop-all gates", {g_h, g_m, g_a, lv}, 4'b1110);
    chk("R4 lite demotes 3 to halt", l_st_o, 1);
    do_tick(2);
    chk("R6 no deep step before threshold seen", lv, 0);
    cyc(1);
    chk("R6 first deep level lowv", lv, 1);
    chk("R6 first deep level status", st_o, 3);
    do_tick(1);
    cyc(1);
    chk("R6 count restarted on step", lv, 1);
    do_tick(1);
    cyc(1);
    do_tick(2);
    cyc(1);
    chk("R6 deepest level lowv", lv, 1);
    chk("R6 deepest level status", st_o, 3);

    vgood = 1'b0;
    do_wake();
    chk("R7 lowv dropped on wake", lv, 0);
    chk("R7 gates held on wake", g_a, 1);
    cyc(3);
    chk("R7 gates held without vgood", g_a, 1);
    chk("R7 status held without vgood", st_o, 3);
    vgood = 1'b1;
    measure("R8 latency from deepest level", 8);
    cyc(4);

    do_req(2'd1);
    do_wake();
    measure("R8 latency from halt", 2);
    cyc(4);

    do_req(2'd3);
    do_wake();
    measure("R8 latency from stop-all", 5);
    cyc(4);

    @(negedge clk); req_valid = 1'b1; req_code = 2'd1; wake = 1'b1;
    @(negedge clk); req_valid = 1'b0; wake = 1'b0;
    chk("R2 request blocked by wake", st_o, 0);
    chk("R2 lite request blocked by wake", l_st_o, 0);
    chk("R10 no lowv in active", lv, 0);
    cyc(2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule